// File: doc/BRIEF.md
# Prefixed Bit-Manipulation ALU

This block is the execution datapath for the second byte of a two-byte bit-manipulation instruction group in an 8-bit processor core. It receives the 8-bit sub-opcode, one 8-bit operand and the current flag nibble. It returns the new byte, the new flags and a write-enable that says whether the byte must be stored back. It also passes out the 3-bit operand selector decoded from the sub-opcode, which the register file or memory path uses. The surrounding core fetches the prefix, reads the operand and writes the result.

The sub-opcode falls into eleven operation classes: four rotates, three shifts, a nibble exchange, and bit test, clear and set on a selectable bit. Each class has its own flag rule. A parameter chooses between a purely combinational path and a version with one output register stage.

Flags travel as a 4-bit vector: bit 3 = Z (zero), bit 2 = N (subtract), bit 1 = H (half carry), bit 0 = C (carry).

Top module: `bitop_alu`

## Requirements
- R1: The class decode uses these sub-opcode ranges (hex): 00-07 circular rotate left, 08-0F circular rotate right, 10-17 rotate left through C, 18-1F rotate right through C, 20-27 shift left, 28-2F arithmetic shift right, 30-37 nibble exchange, 38-3F logical shift right, 40-7F bit test, 80-BF bit clear, C0-FF bit set.
- R2: `target_sel` equals sub-opcode bits 2:0. Codes 0 to 7 select B, C, D, E, H, L, memory at HL and A, in that order.
- R3: Circular rotate left gives {x[6:0],x[7]} with C = x[7]. Circular rotate right gives {x[0],x[7:1]} with C = x[0].
- R4: Rotate left through carry gives {x[6:0],Cin} with C = x[7]. Rotate right through carry gives {Cin,x[7:1]} with C = x[0].
- R5: Shift left gives {x[6:0],0} with C = x[7]. Arithmetic shift right gives {x[7],x[7:1]} with C = x[0]. Logical shift right gives {0,x[7:1]} with C = x[0]. Every carry comes from the operand itself.
- R6: For every rotate and shift, Z is set exactly when the result is zero, and N and H are cleared.
- R7: Nibble exchange gives {x[3:0],x[7:4]}, sets Z from a zero result and clears N, H and C.
- R8: Bit test, with index = sub-opcode bits 5:3, sets Z = NOT x[index], N = 0, H = 1 and keeps C. It drives `result` with the unchanged operand and holds `wr_en` low.
- R9: Bit clear outputs x with bit [index] forced to 0 and passes all four flags through unchanged.
- R10: Bit set outputs x with bit [index] forced to 1 and passes all four flags through unchanged.
- R11: `wr_en` is high for every sub-opcode outside 40-7F.
- R12: With OUT_REG = 1, outputs reflect the inputs sampled at the previous rising clock edge. An active-low reset clears `result`, `flags_out`, `wr_en` and `target_sel` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| sub_op | input | 8 | Second instruction byte |
| operand | input | 8 | Byte being operated on |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 8 | Resulting byte |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| wr_en | output | 1 | Result must be written back |
| target_sel | output | 3 | Operand selector decoded from the sub-opcode |

## Verification
The bench sweeps all 256 sub-opcodes against operands that exercise the class boundaries. These include 0x80 and 0x01, which shift to zero, and operands with a set bit 7 or bit 0 paired with both carry-in values. A design that took the shift carry from some other byte, or fed the old carry into a circular rotate, would show a wrong C or a wrong end bit. Bit test is run with C both set and clear, so a design that cleared C or wrote the result back is caught. Bit clear and set are run with all flags set and all flags clear, so a design that disturbed the flags is caught. Range edges such as 3F/40 and BF/C0 are checked so that an off-by-one class decode produces a wrong result.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   // operation classes decoded from the sub-opcode
   typedef enum logic [3:0] {
      CLS_ROL_CIRC = 4'd0,
      CLS_ROR_CIRC = 4'd1,
      CLS_ROL_CY   = 4'd2,
      CLS_ROR_CY   = 4'd3,
      CLS_SHL      = 4'd4,
      CLS_SHR_ARI  = 4'd5,
      CLS_NIB_XCH  = 4'd6,
      CLS_SHR_LOG  = 4'd7,
      CLS_TEST     = 4'd8,
      CLS_CLEAR    = 4'd9,
      CLS_SETB     = 4'd10
   } op_class_t;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flag_t;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
   import bitop_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0]  sub_op,
   output op_class_t         op_class,
   output logic [2:0]        bit_idx,
   output logic [2:0]        tgt
);
   localparam int GRP_HI = OPC_W - 1;
   localparam int GRP_LO = OPC_W - 2;

   if (OPC_W != 8) begin : g_bad_opc
      $error("bitop_decode: OPC_W must be 8");
   end

   logic [1:0] grp;
   assign grp     = sub_op[GRP_HI:GRP_LO];
   assign bit_idx = sub_op[5:3];
   assign tgt     = sub_op[2:0];

   always_comb begin
      unique case (grp)
         2'b00:   op_class = op_class_t'({1'b0, sub_op[5:3]});
         2'b01:   op_class = CLS_TEST;
         2'b10:   op_class = CLS_CLEAR;
         default: op_class = CLS_SETB;
      endcase
   end
endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
   import bitop_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  op_class_t          op_class,
   input  logic [2:0]         bit_idx,
   input  logic [DATA_W-1:0]  x,
   input  flag_t              fin,
   output logic [DATA_W-1:0]  r,
   output flag_t              fout,
   output logic               wr
);
   localparam int MSB = DATA_W - 1;
   localparam int NIB = DATA_W / 2;

   // one-hot bit mask from the index
   logic [DATA_W-1:0] mask;
   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (bit_idx == i[2:0]);
   end

   logic co;

   always_comb begin
      r    = x;
      co   = 1'b0;
      fout = fin;
      wr   = 1'b1;
      unique case (op_class)
         CLS_ROL_CIRC: begin r = {x[MSB-1:0], x[MSB]}; co = x[MSB]; end
         CLS_ROR_CIRC: begin r = {x[0], x[MSB:1]};     co = x[0];   end
         CLS_ROL_CY:   begin r = {x[MSB-1:0], fin.c};  co = x[MSB]; end
         CLS_ROR_CY:   begin r = {fin.c, x[MSB:1]};    co = x[0];   end
         CLS_SHL:      begin r = {x[MSB-1:0], 1'b0};   co = x[MSB]; end
         CLS_SHR_ARI:  begin r = {x[MSB], x[MSB:1]};   co = x[0];   end
         CLS_NIB_XCH:  begin r = {x[NIB-1:0], x[MSB:NIB]}; co = 1'b0; end
         CLS_SHR_LOG:  begin r = {1'b0, x[MSB:1]};     co = x[0];   end
         CLS_TEST:     begin r = x; wr = 1'b0; end
         CLS_CLEAR:    r = x & ~mask;
         CLS_SETB:     r = x | mask;
         default:      r = x;
      endcase

      if (op_class == CLS_TEST) begin
         fout.z = ~|(x & mask);
         fout.n = 1'b0;
         fout.h = 1'b1;
      end else if (op_class != CLS_CLEAR && op_class != CLS_SETB) begin
         fout.z = ~|r;
         fout.n = 1'b0;
         fout.h = 1'b0;
         fout.c = co;
      end
   end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int OPC_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  sub_op,
   input  logic [DATA_W-1:0] operand,
   input  logic [3:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic [3:0]        flags_out,
   output logic              wr_en,
   output logic [2:0]        target_sel
);
   if (DATA_W != 8) begin : g_bad_width
      $error("bitop_alu: DATA_W must be 8");
   end

   op_class_t         cls;
   logic [2:0]        idx;
   logic [2:0]        tgt_c;
   logic [DATA_W-1:0] res_c;
   flag_t             flg_c;
   logic              wr_c;

   bitop_decode #(.OPC_W(OPC_W)) u_dec (
      .sub_op   (sub_op),
      .op_class (cls),
      .bit_idx  (idx),
      .tgt      (tgt_c)
   );

   bitop_exec #(.DATA_W(DATA_W)) u_exe (
      .op_class (cls),
      .bit_idx  (idx),
      .x        (operand),
      .fin      (flag_t'(flags_in)),
      .r        (res_c),
      .fout     (flg_c),
      .wr       (wr_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result     <= '0;
            flags_out  <= '0;
            wr_en      <= 1'b0;
            target_sel <= '0;
         end else begin
            result     <= res_c;
            flags_out  <= flg_c;
            wr_en      <= wr_c;
            target_sel <= tgt_c;
         end
      end
   end else begin : g_comb
      assign result     = res_c;
      assign flags_out  = flg_c;
      assign wr_en      = wr_c;
      assign target_sel = tgt_c;
   end
endmodule

// File: rtl/bitop_alu_chk.sv
module bitop_alu_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] sub_op,
   input logic [7:0] operand,
   input logic [3:0] flags_in,
   input logic [7:0] result,
   input logic [3:0] flags_out,
   input logic       wr_en,
   input logic [2:0] target_sel
);
   if (OUT_REG) begin : g_seq
      // R2
      target_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> target_sel == $past(sub_op[2:0]));

      // R8
      bit_test_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sub_op[7:6] == 2'b01) |=>
            (!wr_en && flags_out[2:1] == 2'b01 && flags_out[0] == $past(flags_in[0])
             && result == $past(operand)));

      // R11
      write_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sub_op[7:6] != 2'b01) |=> wr_en);

      // R9
      clear_flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sub_op[7:6] == 2'b10) |=>
            (flags_out == $past(flags_in) && result[$past(sub_op[5:3])] == 1'b0));

      // R10
      set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sub_op[7:6] == 2'b11) |=>
            (flags_out == $past(flags_in) && result[$past(sub_op[5:3])] == 1'b1));

      // R7
      nibble_xchg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sub_op[7:3] == 5'b00110) |=>
            (flags_out[2:0] == 3'b000
             && result == {$past(operand[3:0]), $past(operand[7:4])}));

      // R6
      shift_zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sub_op[7:6] == 2'b00) |=>
            (flags_out[2:1] == 2'b00 && flags_out[3] == (result == 8'h00)));
   end else begin : g_cmb
      always_comb begin
         if (rst_n) begin
            // R11
            write_enable_chk: assert (wr_en == (sub_op[7:6] != 2'b01));
            // R2
            target_follow_chk: assert (target_sel == sub_op[2:0]);
            // R6
            shift_zero_flag_chk: assert (sub_op[7:6] != 2'b00 ||
               (flags_out[2:1] == 2'b00 && flags_out[3] == (result == 8'h00)));
            // R9
            clear_flags_keep_chk: assert (sub_op[7:6] != 2'b10 || flags_out == flags_in);
         end
      end
      logic unused_cmb;
      assign unused_cmb = ^{clk, operand};
   end
endmodule

bind bitop_alu bitop_alu_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sub_op     (sub_op),
   .operand    (operand),
   .flags_in   (flags_in),
   .result     (result),
   .flags_out  (flags_out),
   .wr_en      (wr_en),
   .target_sel (target_sel)
);

// File: tb/bitop_alu_test.sv
module bitop_alu_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] sub_op;
   logic [7:0] operand;
   logic [3:0] flags_in;
   logic [7:0] result;
   logic [3:0] flags_out;
   logic       wr_en;
   logic [2:0] target_sel;

   always #10 clk = ~clk;   // 50 MHz

   bitop_alu uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sub_op     (sub_op),
      .operand    (operand),
      .flags_in   (flags_in),
      .result     (result),
      .flags_out  (flags_out),
      .wr_en      (wr_en),
      .target_sel (target_sel)
   );

   int    vectors = 0;
   int    miscompares = 0;
   bit    pend = 0;
   int    e_res, e_flg, e_wr, e_op;
   string e_tag;

   // behavioural reference: integer arithmetic per range of the opcode map
   function automatic void model(input int op, input int x, input int f,
                                 output int r, output int fo, output int w);
      int c, b, z, n, h;
      c = f & 1;
      b = (op >> 3) & 7;
      w = 1;
      if (op < 64) begin
         n = 0; h = 0;
         if (op < 8)       begin r = ((x * 2) + (x / 128)) % 256;  c = x / 128; end // R3
         else if (op < 16) begin r = (x / 2) + (x % 2) * 128;      c = x % 2;   end // R3
         else if (op < 24) begin r = (x * 2 + c) % 256;            c = x / 128; end // R4
         else if (op < 32) begin r = (x / 2) + c * 128;            c = x % 2;   end // R4
         else if (op < 40) begin r = (x * 2) % 256;                c = x / 128; end // R5
         else if (op < 48) begin r = (x / 2) + (x / 128) * 128;    c = x % 2;   end // R5
         else if (op < 56) begin r = (x % 16) * 16 + x / 16;       c = 0;       end // R7
         else              begin r = x / 2;                        c = x % 2;   end // R5
         z = (r == 0) ? 1 : 0;
         fo = z * 8 + n * 4 + h * 2 + c;
      end else if (op < 128) begin                                                // R8
         r = x;
         z = ((x >> b) & 1) ? 0 : 1;
         fo = z * 8 + 2 + c;
         w = 0;
      end else if (op < 192) begin                                                // R9
         r = x & ~(1 << b) & 255;
         fo = f;
      end else begin                                                              // R10
         r = x | (1 << b);
         fo = f;
      end
   endfunction

   function automatic string tag_of(input int op);
      if ((op < 64 && op % 8 == 0) || op == 63 || op == 64 || op == 127
          || op == 128 || op == 191 || op == 192 || op == 255) return "R1";
      if (op < 16)  return "R3";
      if (op < 32)  return "R4";
      if (op >= 48 && op < 56) return "R7";
      if (op < 64)  return "R5";
      if (op < 128) return "R8";
      if (op < 192) return "R9";
      return "R10";
   endfunction

   task automatic check(input string tag, input int act, input int exp, input string what);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s op=%02h actual=%0h expected=%0h", tag, what, e_op, act, exp);
      end
   endtask

   // outputs compared one clock after the drive (R12 latency)
   task automatic compare_pending();
      if (pend) begin
         check(e_tag, {24'd0, result, flags_out}, e_res * 16 + e_flg, "result/flags");
         check("R11", int'(wr_en), e_wr, "wr_en");
         check("R2", int'(target_sel), e_op % 8, "target_sel");
         if (e_op < 64 && !(e_op >= 48 && e_op < 56))
            check("R6", int'(flags_out[2:1]), 0, "N/H after shift");
      end
   endtask

   task automatic apply(input int op, input int x, input int f);
      @(negedge clk);
      compare_pending();
      sub_op   = op[7:0];
      operand  = x[7:0];
      flags_in = f[3:0];
      model(op, x, f, e_res, e_flg, e_wr);
      e_op  = op;
      e_tag = tag_of(op);
      pend  = 1;
   endtask

   task automatic check_reset_state();
      check("R12", int'(result), 0, "reset result");
      check("R12", int'(flags_out), 0, "reset flags");
      check("R12", int'(wr_en), 0, "reset wr_en");
      check("R12", int'(target_sel), 0, "reset target_sel");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int xs[8];
      xs = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'h5A, 8'hA5, 8'h7E, 8'h10};
      rst_n    = 1'b0;
      sub_op   = 8'hC7;
      operand  = 8'hFF;
      flags_in = 4'hF;
      e_op     = 0;
      repeat (3) @(negedge clk);
      check_reset_state();                       // R12 reset clears outputs
      rst_n = 1'b1;

      // every sub-opcode against edge operands, both carry-in values
      for (int op = 0; op < 256; op++) begin
         for (int k = 0; k < 8; k++) begin
            apply(op, xs[k], (k % 2) ? 4'hF : 4'h0);
         end
         apply(op, int'($urandom_range(255)), int'($urandom_range(15)));
      end

      // R8 bit test keeps C both ways; R9/R10 flags pass through
      for (int b = 0; b < 8; b++) begin
         apply(64 + b * 8, 1 << b, 4'h1);
         apply(64 + b * 8, ~(1 << b) & 255, 4'h0);
         apply(128 + b * 8 + 7, 255, 4'hA);
         apply(192 + b * 8 + 6, 0, 4'h5);
      end

      // mid-run reset: outputs must drop at once (R12)
      @(negedge clk);
      compare_pending();
      pend  = 0;
      rst_n = 1'b0;
      #1;
      check_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      apply(8'h37, 8'h00, 4'h0);                 // R7 zero result
      apply(8'h3F, 8'h01, 4'h0);                 // R5 logical shift to zero
      apply(8'h2F, 8'h81, 4'h0);                 // R5 sign kept
      @(negedge clk);
      compare_pending();
      pend = 0;

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule